// File: doc/BRIEF.md
# Half-Rate Quadrature-Sampled Bang-Bang Phase Detector

This block turns the samples of a half-rate receiver front end into data and clock corrections. In each half-rate period, four samples of the incoming serial line arrive in order. The rising edge of the in-phase clock gives the centre of an even bit. The rising edge of the quadrature clock gives the boundary after that bit. The falling edge of the in-phase clock gives the centre of the odd bit. The falling edge of the quadrature clock gives the boundary after the odd bit. Each sample enters on one system-clock cycle, together with a 2-bit phase index that names the edge it came from.

The block demultiplexes the line into an even stream and an odd stream, both aligned to the same period. It also makes a binary early/late/hold decision for each bit pair of the period. The first pair runs from the even bit to the odd bit. The second pair runs from the odd bit to the even bit of the next period. So a period's results can only be complete once the next period's even sample has arrived. At that point the block issues one strobe that carries:
- both data bits,
- an up/down pair per bit pair,
- a signed net count ready to feed a digital loop filter.

The decision ignores the size of the phase error; only its sign matters. Spacing errors between the two half-rate edges are not corrected.

Top module: `qpd_halfrate`

## Requirements
- R1: A synchronous reset clears every stored sample and completion flag. In the cycle after a reset edge, `pair_valid_o`, `even_o`, `odd_o`, `up_o`, `dn_o` and `net_o` are all zero.
- R2: Phase codes are 0 = even centre, 1 = boundary after even, 2 = odd centre, 3 = boundary after odd. A phase-0 sample that completes a period raises `pair_valid_o` for exactly one cycle, on the clock edge that captures it. That strobe presents the previous period's even bit on `even_o` and its odd bit on `odd_o`, in the same cycle.
- R3: If the two centre samples of a pair are equal, that pair produces neither up nor down, whatever its boundary sample holds.
- R4: When a pair's centres differ and the boundary equals the earlier centre, the clock is early. The block sets that pair's `dn_o` bit and clears its `up_o` bit.
- R5: When a pair's centres differ and the boundary equals the later centre, the clock is late. The block sets that pair's `up_o` bit and clears its `dn_o` bit.
- R6: Bit 0 of `up_o`/`dn_o` is the even-to-odd pair, judged with the phase-1 sample. Bit 1 is the odd-to-next-even pair, judged with the phase-3 sample and the newly arriving phase-0 sample.
- R7: `net_o` is a 3-bit two's complement value. It equals the number of set `up_o` bits minus the number of set `dn_o` bits, so it lies in -2..+2.
- R8: In every cycle without a strobe, `up_o`, `dn_o` and `net_o` are zero, and `even_o`/`odd_o` keep their last strobed values.
- R9: No strobe is issued until phases 0, 1, 2 and 3 of one period have all been captured since the last phase-0 sample (or since reset). A period missing any of its samples produces no strobe when the next phase-0 sample arrives.
- R10: A sample presented while `smp_valid_i` is low changes neither the stored samples nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one sample per cycle at most |
| rst_i | input | 1 | Synchronous active-high reset |
| smp_valid_i | input | 1 | Qualifies the sample on this cycle |
| smp_bit_i | input | 1 | Sliced line value at the named clock edge |
| smp_phase_i | input | 2 | Edge index: 0 even centre, 1 boundary, 2 odd centre, 3 boundary |
| pair_valid_o | output | 1 | One-cycle strobe for a completed period |
| even_o | output | 1 | Even-position bit of the completed period |
| odd_o | output | 1 | Odd-position bit of the completed period |
| up_o | output | 2 | Late decisions per pair (bit 0 even-to-odd, bit 1 odd-to-next) |
| dn_o | output | 2 | Early decisions per pair, same bit order |
| net_o | output | 3 | Signed sum: ups minus downs |

## Verification
An all-zero stream shows that equal centres never produce a correction. A run of ones with disagreeing boundaries shows the same thing when the boundary is noisy. Alternating data with boundaries that follow the earlier centre drives both pairs early and gives -2. Boundaries that follow the later centre drive both pairs late and give +2. Mixed periods set one pair early and the other late, or one late and one holding. These show which bus bit belongs to which pair and that the net count sums them with sign. Unqualified samples, a period with a skipped sample, and a reset in the middle of a period show that only complete periods ever strobe.

// File: rtl/qpd_pkg.sv
package qpd_pkg;

    // Sample edges per half-rate period, in arrival order
    localparam int PHASES = 4;
    localparam int PH_W   = $clog2(PHASES);
    // One decision per bit; two bits per half-rate period
    localparam int PAIRS  = PHASES / 2;
    // Signed range -PAIRS..+PAIRS
    localparam int NET_W  = $clog2(PAIRS + 1) + 1;
    // Slot positions of the two data-centre samples
    localparam int EVEN_SLOT = 0;
    localparam int ODD_SLOT  = PHASES / 2;

    typedef struct packed {
        logic [PHASES-1:0]       slot;
        logic [PHASES-1:0]       fill;
        logic                    vld;
        logic                    even;
        logic                    odd;
        logic [PAIRS-1:0]        up;
        logic [PAIRS-1:0]        dn;
        logic signed [NET_W-1:0] net;
    } qpd_state_t;

endpackage

// File: rtl/qpd_bb_decide.sv
module qpd_bb_decide (
    input  logic centre_a_i,
    input  logic edge_i,
    input  logic centre_b_i,
    output logic early_o,
    output logic late_o
);

    logic moved;

    always_comb begin
        moved   = centre_a_i ^ centre_b_i;
        // Boundary still shows the old bit: sampling clock ran ahead
        early_o = moved & (edge_i == centre_a_i);
        // Boundary already shows the new bit: sampling clock lags
        late_o  = moved & (edge_i == centre_b_i);
    end

endmodule

// File: rtl/qpd_net_sum.sv
module qpd_net_sum #(
    parameter int PAIRS = 2,
    parameter int NET_W = 3
) (
    input  logic [PAIRS-1:0]        up_i,
    input  logic [PAIRS-1:0]        dn_i,
    output logic signed [NET_W-1:0] net_o
);

    logic signed [NET_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < PAIRS; i++) begin
            acc = acc + $signed({{(NET_W-1){1'b0}}, up_i[i]})
                      - $signed({{(NET_W-1){1'b0}}, dn_i[i]});
        end
        net_o = acc;
    end

endmodule

// File: rtl/qpd_halfrate.sv
module qpd_halfrate
    import qpd_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    smp_valid_i,
    input  logic                    smp_bit_i,
    input  logic [PH_W-1:0]         smp_phase_i,
    output logic                    pair_valid_o,
    output logic                    even_o,
    output logic                    odd_o,
    output logic [PAIRS-1:0]        up_o,
    output logic [PAIRS-1:0]        dn_o,
    output logic signed [NET_W-1:0] net_o
);

    qpd_state_t st_d, st_q;

    logic [PAIRS-1:0]        early_w;
    logic [PAIRS-1:0]        late_w;
    logic signed [NET_W-1:0] net_w;

    // One decision slice per bit pair; the last pair closes on the
    // incoming even-centre sample of the following period.
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        logic next_centre;
        if (p == PAIRS - 1) begin : g_wrap
            assign next_centre = smp_bit_i;
        end else begin : g_inner
            assign next_centre = st_q.slot[2*p+2];
        end
        qpd_bb_decide i_dec (
            .centre_a_i (st_q.slot[2*p]),
            .edge_i     (st_q.slot[2*p+1]),
            .centre_b_i (next_centre),
            .early_o    (early_w[p]),
            .late_o     (late_w[p])
        );
    end

    qpd_net_sum #(
        .PAIRS (PAIRS),
        .NET_W (NET_W)
    ) i_sum (
        .up_i  (late_w),
        .dn_i  (early_w),
        .net_o (net_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.up  = '0;
        st_d.dn  = '0;
        st_d.net = '0;
        if (smp_valid_i) begin
            st_d.slot[smp_phase_i] = smp_bit_i;
            if (smp_phase_i == PH_W'(EVEN_SLOT)) begin
                // New period starts: only its even centre is known
                st_d.fill = PHASES'(1);
                if (&st_q.fill) begin
                    st_d.vld  = 1'b1;
                    st_d.even = st_q.slot[EVEN_SLOT];
                    st_d.odd  = st_q.slot[ODD_SLOT];
                    st_d.up   = late_w;
                    st_d.dn   = early_w;
                    st_d.net  = net_w;
                end
            end else begin
                st_d.fill[smp_phase_i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pair_valid_o = st_q.vld;
    assign even_o       = st_q.even;
    assign odd_o        = st_q.odd;
    assign up_o         = st_q.up;
    assign dn_o         = st_q.dn;
    assign net_o        = st_q.net;

    AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (rst_i) $past(rst_i) |-> (!pair_valid_o && !even_o && !odd_o)); // R1
    AST_STROBE_ON_EVEN: assert property (@(posedge clk_i) disable iff (rst_i) pair_valid_o |-> $past(smp_valid_i && (smp_phase_i == PH_W'(EVEN_SLOT)))); // R2
    AST_HOLD_PAIR0: assert property (@(posedge clk_i) disable iff (rst_i) (pair_valid_o && (even_o == odd_o)) |-> (!up_o[0] && !dn_o[0])); // R3
    AST_UPDN_EXCL: assert property (@(posedge clk_i) disable iff (rst_i) (up_o & dn_o) == '0); // R4
    AST_NET_RANGE: assert property (@(posedge clk_i) disable iff (rst_i) (net_o <= $signed(NET_W'(PAIRS))) && (net_o >= -$signed(NET_W'(PAIRS)))); // R7
    AST_NET_COUNT: assert property (@(posedge clk_i) disable iff (rst_i) int'(net_o) == ($countones(up_o) - $countones(dn_o))); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i) !pair_valid_o |-> (up_o == '0 && dn_o == '0 && net_o == '0)); // R8
    AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (rst_i) (!pair_valid_o && !$past(rst_i)) |-> ($stable(even_o) && $stable(odd_o))); // R8

endmodule

// File: tb/test_qpd_halfrate.sv
`timescale 1ns/1ps
module test_qpd_halfrate;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_valid = 1'b0;
    logic       smp_bit = 1'b0;
    logic [1:0] smp_phase = 2'd0;
    logic       pair_valid;
    logic       even_b;
    logic       odd_b;
    logic [1:0] up_b;
    logic [1:0] dn_b;
    logic signed [2:0] net_b;

    int checks = 0;
    int failures = 0;
    bit cur_e = 1'b0;
    bit last_e = 1'b0;
    bit last_o = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    qpd_halfrate i_qpd_halfrate (
        .clk_i        (clk),
        .rst_i        (rst),
        .smp_valid_i  (smp_valid),
        .smp_bit_i    (smp_bit),
        .smp_phase_i  (smp_phase),
        .pair_valid_o (pair_valid),
        .even_o       (even_b),
        .odd_o        (odd_b),
        .up_o         (up_b),
        .dn_o         (dn_b),
        .net_o        (net_b)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at a falling edge; return at the next falling edge, after
    // the rising edge that captured the sample.
    task automatic push(input bit v, input bit b, input int ph);
        smp_valid = v;
        smp_bit   = b;
        smp_phase = 2'(ph);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Bench model of one pair decision: {up, dn}
    function automatic bit [1:0] model(input bit a, input bit e, input bit c);
        if (a == c) return 2'b00;
        if (e == a) return 2'b01;
        return 2'b10;
    endfunction

    task automatic expect_quiet(input string req);
        check({req, " strobe low"}, pair_valid, 0);
        check({req, " up zero"}, up_b, 0);
        check({req, " dn zero"}, dn_b, 0);
        check({req, " net zero"}, net_b, 0);
    endtask

    task automatic expect_strobe(input string req, input bit e, input bit o,
                                 input bit [1:0] d0, input bit [1:0] d1);
        int n;
        n = int'(d0[1]) + int'(d1[1]) - int'(d0[0]) - int'(d1[0]);
        check({req, " strobe"}, pair_valid, 1);
        check({req, " even"}, even_b, e);
        check({req, " odd"}, odd_b, o);
        check({req, " up"}, up_b, {d1[1], d0[1]});
        check({req, " dn"}, dn_b, {d1[0], d0[0]});
        check({req, " net R7"}, net_b, n);
        last_e = e;
        last_o = o;
    endtask

    task automatic start_stream(input bit e);
        push(1'b1, e, 0);
        check("R9 lone even", pair_valid, 0);
        cur_e = e;
    endtask

    task automatic run_period(input string req, input bit b0, input bit o,
                              input bit b1, input bit en);
        push(1'b1, b0, 1);
        check({req, " R9 mid1"}, pair_valid, 0);
        push(1'b1, o, 2);
        check({req, " R9 mid2"}, pair_valid, 0);
        push(1'b1, b1, 3);
        check({req, " R9 mid3"}, pair_valid, 0);
        push(1'b1, en, 0);
        expect_strobe(req, cur_e, o, model(cur_e, b0, o), model(o, b1, en));
        cur_e = en;
    endtask

    task automatic t_reset();
        expect_quiet("R1 reset");
        check("R1 even", even_b, 0);
        check("R1 odd", odd_b, 0);
    endtask

    task automatic t_patterns();
        start_stream(1'b0);
        run_period("R3 zeros", 1'b0, 1'b0, 1'b0, 1'b0);
        run_period("R4 both early", 1'b0, 1'b1, 1'b1, 1'b0);
        run_period("R5 both late", 1'b1, 1'b1, 1'b0, 1'b0);
        run_period("R6 early/late", 1'b0, 1'b1, 1'b0, 1'b0);
        run_period("R6 late/hold", 1'b1, 1'b1, 1'b1, 1'b1);
        run_period("R3 ones noisy edge", 1'b0, 1'b1, 1'b0, 1'b1);
        run_period("R2 odd differs", 1'b1, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_hold();
        for (int i = 0; i < 3; i++) begin
            push(1'b0, ~last_e, 0);
            expect_quiet("R8 idle");
            check("R8 even held", even_b, last_e);
            check("R8 odd held", odd_b, last_o);
        end
    endtask

    task automatic t_invalid();
        // cur_e = 1 here; unqualified samples carry conflicting values
        push(1'b1, 1'b1, 1);
        push(1'b0, 1'b0, 0);
        check("R10 no strobe", pair_valid, 0);
        push(1'b1, 1'b0, 2);
        push(1'b0, 1'b1, 2);
        push(1'b0, 1'b0, 3);
        check("R10 no strobe 2", pair_valid, 0);
        push(1'b1, 1'b1, 3);
        push(1'b1, 1'b1, 0);
        // even 1, edge 1, odd 0 -> early; odd 0, edge 1, next 1 -> late
        expect_strobe("R10 stored kept", 1'b1, 1'b0, 2'b01, 2'b10);
        cur_e = 1'b1;
    endtask

    task automatic t_missing();
        push(1'b1, 1'b0, 1);
        push(1'b1, 1'b0, 3);
        push(1'b1, 1'b0, 0);
        expect_quiet("R9 missing odd");
        cur_e = 1'b0;
        run_period("R9 recovers", 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_midreset();
        push(1'b1, 1'b1, 1);
        push(1'b1, 1'b1, 2);
        push(1'b1, 1'b1, 3);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        push(1'b1, 1'b1, 0);
        expect_quiet("R9 after reset");
        cur_e = 1'b1;
        run_period("R1 restart", 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_patterns();
        t_hold();
        t_invalid();
        t_missing();
        t_midreset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule